// File: doc/BRIEF.md
# Raster Scan Timing Generator

This block produces the beam position for a raster display from four programmable registers. A pixel counter steps once per pixel clock and wraps at the end of each scan line. A line counter steps at each line wrap and wraps at the end of the frame. The block combines both counters with the programmed visible window to produce a display-enable flag and a one-cycle frame-start pulse. It also keeps a framebuffer byte address for the current line. That address is reloaded with the programmed start address at each frame and advances by the programmed pitch at every line.

Horizontal sizes are programmed in eight-pixel character cells. The start address and the pitch are programmed in eight-byte units. Software writes the horizontal, vertical and scan-address registers through a single write port. While the raster is running, new values are staged and applied together at the next frame boundary, so a frame is never drawn with mixed geometry. While the raster is stopped, new values apply at once. A run bit in the control register starts and stops the raster. The frame rate is therefore the pixel clock divided by the horizontal total and by the vertical total.

Top module: `crtc_raster_top`

## Requirements
- R1: Reset drives pixel count, line count, display-enable, frame-start and line address to zero, with the raster stopped.
- R2: While running, the pixel count rises by one per clock and returns to 0 after pixel (H[7:0]+1)*8-1, where H is the horizontal register (select 0).
- R3: The line count rises by one each time the pixel count wraps and returns to 0 after line V[10:0], where V is the vertical register (select 1); it changes only together with a pixel-count wrap.
- R4: Display-enable is high exactly when the raster runs, the pixel count is below (H[23:16]+1)*8 and the line count is at most V[26:16]; it is low whenever the raster is stopped.
- R5: Frame-start is high for the single cycle in which a running raster has both counts at 0, so its period is the horizontal total times the vertical total in clocks.
- R6: The line address equals S[19:0]*8 on line 0 and grows by S[31:22]*8 (modulo 2^24) at each following line, where S is the scan register (select 2); it changes only when the pixel count is 0.
- R7: Writing the control register (select 3) with bit 25 set starts the raster: in the cycle after the write both counts are 0 and frame-start is high.
- R8: Writing the control register with bit 25 clear stops the raster: from the cycle after the write, both counts are 0 and display-enable and frame-start stay low.
- R9: A write to the horizontal, vertical or scan register while running leaves the current frame unchanged and governs every frame from the next frame start on; while stopped, the write applies from the next cycle.
- R10: All bits outside the fields named above are ignored, including every control-register bit other than bit 25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 horizontal, 1 vertical, 2 scan address, 3 control |
| regWrData | input | 32 | Register write data |
| hCount | output | 11 | Pixel position within the line |
| vCount | output | 11 | Line position within the frame |
| displayEnable | output | 1 | High inside the visible window |
| frameStart | output | 1 | One-cycle pulse at pixel 0 of line 0 |
| lineAddr | output | 24 | Framebuffer byte address of the current line |

## Verification
The counters and the line address are registered, so each of them shows the effect of a clock edge one cycle later. Display-enable and frame-start are decoded from the counter registers and change in the same cycle as the counters. A register write therefore shows up one cycle after its strobe: a start or stop is visible in the counters, and a staged write made while stopped is visible in the line address. A staged write made while running first shows at the cycle of the next frame-start pulse. The bench drives on the falling edge and samples just before the next falling edge. It counts elapsed cycles from the first cycle of a run to predict every counter, flag and address value, and it sets the expected frame-start cycles of a mid-frame reprogramming from the old and new totals.

// File: rtl/crtc_raster_pkg.sv
package crtc_raster_pkg;

  // Register select codes presented on regSel
  typedef enum logic [1:0] {
    SEL_HORZ = 2'd0,
    SEL_VERT = 2'd1,
    SEL_SCAN = 2'd2,
    SEL_CTRL = 2'd3
  } regSel_e;

  localparam int NUM_TIMING_REGS = 3;

  // Strobes from the sequencing control into the datapath
  typedef struct packed {
    logic loadActive;  // copy staged geometry into the active set, reload line address
    logic stepLine;    // advance line address by one pitch
  } rasterStrobe_t;

endpackage

// File: rtl/crtc_raster_dp.sv
module crtc_raster_dp
  import crtc_raster_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int CHAR_PIX   = 8,
  parameter int UNIT_BYTES = 8,
  parameter int H_FIELD_W  = 8,
  parameter int H_TOT_LSB  = 0,
  parameter int H_DISP_LSB = 16,
  parameter int V_FIELD_W  = 11,
  parameter int V_TOT_LSB  = 0,
  parameter int V_DISP_LSB = 16,
  parameter int START_W    = 20,
  parameter int PITCH_LSB  = 22,
  parameter int PITCH_W    = 10,
  parameter int ADDR_W     = 24,
  localparam int CHAR_SH   = $clog2(CHAR_PIX),
  localparam int UNIT_SH   = $clog2(UNIT_BYTES),
  localparam int HCNT_W    = H_FIELD_W + CHAR_SH,
  localparam int VCNT_W    = V_FIELD_W,
  localparam int SEL_W     = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                regWrEn,
  input  logic [SEL_W-1:0]    regSel,
  input  logic [REG_W-1:0]    regWrData,
  input  rasterStrobe_t       strobe,
  output logic [HCNT_W-1:0]   hLastPix,
  output logic [HCNT_W-1:0]   hDispLastPix,
  output logic [VCNT_W-1:0]   vLastLine,
  output logic [VCNT_W-1:0]   vDispLast,
  output logic [ADDR_W-1:0]   lineAddr
);

  // Staged and active copies of each timing register
  for (genvar i = 0; i < NUM_TIMING_REGS; i++) begin : g_bank
    logic [REG_W-1:0] stagedQ;
    logic [REG_W-1:0] stagedD;
    logic [REG_W-1:0] activeQ;

    always_comb begin
      stagedD = stagedQ;
      if (regWrEn && (regSel == SEL_W'(i))) stagedD = regWrData;
    end

    always_ff @(posedge clk) begin
      if (rst) stagedQ <= '0;
      else     stagedQ <= stagedD;
    end

    always_ff @(posedge clk) begin
      if (rst)                    activeQ <= '0;
      else if (strobe.loadActive) activeQ <= stagedD;
    end
  end

  logic [REG_W-1:0] horzAct;
  logic [REG_W-1:0] vertAct;
  logic [REG_W-1:0] scanAct;
  logic [REG_W-1:0] scanNext;

  assign horzAct  = g_bank[0].activeQ;
  assign vertAct  = g_bank[1].activeQ;
  assign scanAct  = g_bank[2].activeQ;
  assign scanNext = g_bank[2].stagedD;

  // Character cells expand to pixels: last pixel index = cells*CHAR_PIX + CHAR_PIX-1
  assign hLastPix     = {horzAct[H_TOT_LSB  +: H_FIELD_W], {CHAR_SH{1'b1}}};
  assign hDispLastPix = {horzAct[H_DISP_LSB +: H_FIELD_W], {CHAR_SH{1'b1}}};
  assign vLastLine    = vertAct[V_TOT_LSB  +: V_FIELD_W];
  assign vDispLast    = vertAct[V_DISP_LSB +: V_FIELD_W];

  logic [ADDR_W-1:0] startBytes;
  logic [ADDR_W-1:0] pitchBytes;

  assign startBytes = ADDR_W'({scanNext[START_W-1:0], {UNIT_SH{1'b0}}});
  assign pitchBytes = ADDR_W'({scanAct[PITCH_LSB +: PITCH_W], {UNIT_SH{1'b0}}});

  always_ff @(posedge clk) begin
    if (rst)                    lineAddr <= '0;
    else if (strobe.loadActive) lineAddr <= startBytes;
    else if (strobe.stepLine)   lineAddr <= lineAddr + pitchBytes;
  end

  // Bits outside the decoded fields are deliberately left unused
  logic unusedRegBits;
  assign unusedRegBits = ^{horzAct, vertAct, scanAct};

endmodule

// File: rtl/crtc_raster_ctrl.sv
module crtc_raster_ctrl
  import crtc_raster_pkg::*;
#(
  parameter int HCNT_W = 11,
  parameter int VCNT_W = 11,
  localparam int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic              enableData,
  input  logic [HCNT_W-1:0] hLastPix,
  input  logic [HCNT_W-1:0] hDispLastPix,
  input  logic [VCNT_W-1:0] vLastLine,
  input  logic [VCNT_W-1:0] vDispLast,
  output rasterStrobe_t     strobe,
  output logic [HCNT_W-1:0] hCount,
  output logic [VCNT_W-1:0] vCount,
  output logic              displayEnable,
  output logic              frameStart,
  output logic              runFlag
);

  logic runNext;
  logic advance;
  logic lineEnd;
  logic frameEnd;

  always_comb begin
    runNext = runFlag;
    if (regWrEn && (regSel == SEL_W'(SEL_CTRL))) runNext = enableData;
  end

  // Counting needs the raster running now and not being stopped at this edge
  assign advance  = runFlag && runNext;
  assign lineEnd  = advance && (hCount == hLastPix);
  assign frameEnd = lineEnd && (vCount == vLastLine);

  always_ff @(posedge clk) begin
    if (rst) runFlag <= 1'b0;
    else     runFlag <= runNext;
  end

  always_ff @(posedge clk) begin
    if (rst || !advance) hCount <= '0;
    else if (lineEnd)    hCount <= '0;
    else                 hCount <= hCount + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !advance) vCount <= '0;
    else if (frameEnd)   vCount <= '0;
    else if (lineEnd)    vCount <= vCount + 1'b1;
  end

  always_comb begin
    strobe.loadActive = !runFlag || frameEnd;
    strobe.stepLine   = lineEnd && !frameEnd;
  end

  assign displayEnable = runFlag && (hCount <= hDispLastPix) && (vCount <= vDispLast);
  assign frameStart    = runFlag && (hCount == '0) && (vCount == '0);

endmodule

// File: rtl/crtc_raster_top.sv
module crtc_raster_top
  import crtc_raster_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int CHAR_PIX   = 8,
  parameter int UNIT_BYTES = 8,
  parameter int H_FIELD_W  = 8,
  parameter int V_FIELD_W  = 11,
  parameter int START_W    = 20,
  parameter int PITCH_W    = 10,
  parameter int ADDR_W     = 24,
  parameter int ENABLE_BIT = 25,
  localparam int HCNT_W    = H_FIELD_W + $clog2(CHAR_PIX),
  localparam int VCNT_W    = V_FIELD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [REG_W-1:0]  regWrData,
  output logic [HCNT_W-1:0] hCount,
  output logic [VCNT_W-1:0] vCount,
  output logic              displayEnable,
  output logic              frameStart,
  output logic [ADDR_W-1:0] lineAddr
);

  rasterStrobe_t     strobe;
  logic [HCNT_W-1:0] hLastPix;
  logic [HCNT_W-1:0] hDispLastPix;
  logic [VCNT_W-1:0] vLastLine;
  logic [VCNT_W-1:0] vDispLast;
  logic              runFlag;

  crtc_raster_dp #(
    .REG_W     (REG_W),
    .CHAR_PIX  (CHAR_PIX),
    .UNIT_BYTES(UNIT_BYTES),
    .H_FIELD_W (H_FIELD_W),
    .V_FIELD_W (V_FIELD_W),
    .START_W   (START_W),
    .PITCH_W   (PITCH_W),
    .ADDR_W    (ADDR_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .regWrEn     (regWrEn),
    .regSel      (regSel),
    .regWrData   (regWrData),
    .strobe      (strobe),
    .hLastPix    (hLastPix),
    .hDispLastPix(hDispLastPix),
    .vLastLine   (vLastLine),
    .vDispLast   (vDispLast),
    .lineAddr    (lineAddr)
  );

  crtc_raster_ctrl #(
    .HCNT_W(HCNT_W),
    .VCNT_W(VCNT_W)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .regWrEn      (regWrEn),
    .regSel       (regSel),
    .enableData   (regWrData[ENABLE_BIT]),
    .hLastPix     (hLastPix),
    .hDispLastPix (hDispLastPix),
    .vLastLine    (vLastLine),
    .vDispLast    (vDispLast),
    .strobe       (strobe),
    .hCount       (hCount),
    .vCount       (vCount),
    .displayEnable(displayEnable),
    .frameStart   (frameStart),
    .runFlag      (runFlag)
  );

endmodule

// File: rtl/crtc_raster_checker.sv
module crtc_raster_checker #(
  parameter int REG_W      = 32,
  parameter int HCNT_W     = 11,
  parameter int VCNT_W     = 11,
  parameter int ADDR_W     = 24,
  parameter int ENABLE_BIT = 25
) (
  input logic              clk,
  input logic              rst,
  input logic              regWrEn,
  input logic [1:0]        regSel,
  input logic [REG_W-1:0]  regWrData,
  input logic [HCNT_W-1:0] hCount,
  input logic [VCNT_W-1:0] vCount,
  input logic              displayEnable,
  input logic              frameStart,
  input logic [ADDR_W-1:0] lineAddr,
  input logic              runFlag
);

  // R2: pixel count steps by one inside a running line
  a_r2_pixel_step: assert property (@(posedge clk) disable iff (rst)
    (runFlag && hCount != '0) |-> (hCount == $past(hCount) + 1'b1));

  // R3: the line count only moves together with a pixel wrap
  a_r3_line_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (vCount != $past(vCount)) |-> (hCount == '0));

  // R4: no visible window while stopped
  a_r4_idle_blank: assert property (@(posedge clk) disable iff (rst)
    !runFlag |-> (!displayEnable && !frameStart));

  // R5: pixel 0 of line 0 is always visible
  a_r5_start_visible: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> displayEnable);

  // R6: address holds away from the first pixel of a line
  a_r6_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (hCount != '0) |-> $stable(lineAddr));

  // R8: a stop write clears the position in the next cycle
  a_r8_stop_clears: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regSel == 2'd3 && !regWrData[ENABLE_BIT]) |=>
      (hCount == '0 && vCount == '0 && !displayEnable));

endmodule

bind crtc_raster_top crtc_raster_checker #(
  .REG_W     (REG_W),
  .HCNT_W    (HCNT_W),
  .VCNT_W    (VCNT_W),
  .ADDR_W    (ADDR_W),
  .ENABLE_BIT(ENABLE_BIT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .regWrEn      (regWrEn),
  .regSel       (regSel),
  .regWrData    (regWrData),
  .hCount       (hCount),
  .vCount       (vCount),
  .displayEnable(displayEnable),
  .frameStart   (frameStart),
  .lineAddr     (lineAddr),
  .runFlag      (runFlag)
);

// File: tb/crtc_raster_top_tb.sv
`timescale 1ns/1ps
module crtc_raster_top_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [31:0] regWrData = '0;
  logic [10:0] hCount;
  logic [10:0] vCount;
  logic        displayEnable;
  logic        frameStart;
  logic [23:0] lineAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  crtc_raster_top u_dut (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .hCount(hCount), .vCount(vCount), .displayEnable(displayEnable),
    .frameStart(frameStart), .lineAddr(lineAddr)
  );

  // {horizontal, vertical, scan} register values per run
  localparam logic [95:0] VECS [4] = '{
    {32'h0000_0000, 32'h0001_0002, 32'h0100_0010},
    {32'h0000_0002, 32'h0002_0004, 32'hFFCF_FFFF},
    {32'h0001_0001, 32'h0000_0000, 32'h0040_0000},
    {32'hAB05_CD03, 32'hF807_F803, 32'h00B0_0003}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int fs1;
    int fs2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check({hCount, vCount, displayEnable, frameStart, lineAddr} == '0, "R1 reset",
          {hCount, vCount, displayEnable, frameStart, lineAddr}, 64'd0);

    // Table walk: R2 R3 R4 R5 R6 R7 R10
    foreach (VECS[k]) begin
      logic [31:0] hR, vR, sR;
      int hTot, hDisp, vTot, vDisp;
      logic [23:0] startB, pitchB;
      {hR, vR, sR} = VECS[k];
      hTot   = (int'(hR[7:0]) + 1) * 8;
      hDisp  = (int'(hR[23:16]) + 1) * 8;
      vTot   = int'(vR[10:0]) + 1;
      vDisp  = int'(vR[26:16]) + 1;
      startB = 24'({sR[19:0], 3'b000});
      pitchB = 24'({sR[31:22], 3'b000});
      writeReg(2'd3, 32'h0000_0000);
      writeReg(2'd0, hR);
      writeReg(2'd1, vR);
      writeReg(2'd2, sR);
      writeReg(2'd3, 32'h0A55_00F0);  // R7 start, R10 other control bits set
      for (int t = 0; t < 2 * hTot * vTot + 3; t++) begin
        int eh, ev;
        bit ede, efs;
        logic [23:0] ea;
        eh  = t % hTot;
        ev  = (t / hTot) % vTot;
        ede = (eh < hDisp) && (ev < vDisp);
        efs = (eh == 0) && (ev == 0);
        ea  = startB + 24'(ev) * pitchB;
        // R2 R3 R4 R5 R6 R10
        check(hCount == 11'(eh) && vCount == 11'(ev) && displayEnable == ede &&
              frameStart == efs && lineAddr == ea, "R2/R3/R4/R5/R6 raster",
              {hCount, vCount, displayEnable, frameStart, lineAddr},
              {11'(eh), 11'(ev), ede, efs, ea});
        @(negedge clk);
      end
    end

    // R9: mid-frame reprogramming while running
    writeReg(2'd3, 32'h0);
    writeReg(2'd0, 32'h0000_0000);
    writeReg(2'd1, 32'h0001_0002);
    writeReg(2'd2, 32'h0000_0000);
    writeReg(2'd3, 32'h0200_0000);
    fs1 = 0; fs2 = 0;
    for (int t = 1; t <= 80; t++) begin
      @(negedge clk);
      if (frameStart && fs1 == 0) fs1 = t;
      else if (frameStart && fs2 == 0) fs2 = t;
      if (t == 10) check(hCount == 11'd2, "R9 old width kept", 64'(hCount), 64'd2);
      if (t == 36) check(hCount == 11'd12, "R9 new width applied", 64'(hCount), 64'd12);
      regWrEn = (t == 5); regSel = 2'd0; regWrData = 32'h0000_0001;
    end
    check(fs1 == 24, "R9 first frame length", 64'(fs1), 64'd24);
    check(fs2 == 72, "R5 new frame period", 64'(fs2), 64'd72);

    // R8: stop mid-line
    writeReg(2'd3, 32'h0000_0000);
    check(hCount == '0 && vCount == '0 && !displayEnable && !frameStart, "R8 stop",
          {hCount, vCount, displayEnable, frameStart}, 64'd0);
    repeat (3) @(negedge clk);
    check(hCount == '0 && !displayEnable, "R8 stays stopped",
          {hCount, displayEnable}, 64'd0);

    // R10: control write with only bit 25 clear keeps the raster stopped
    writeReg(2'd3, 32'hFDFF_FFFF);
    repeat (3) @(negedge clk);
    check(hCount == '0 && !displayEnable && !frameStart, "R10 stopped with junk bits",
          {hCount, displayEnable, frameStart}, 64'd0);

    // R9: scan write while stopped applies on the next cycle
    writeReg(2'd2, 32'h0000_0123);
    check(lineAddr == 24'h000918, "R9 idle write immediate", 64'(lineAddr), 64'h918);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule